// File: doc/BRIEF.md
# Serial Module Control Register and Bus Glue

This block sits between a 16-bit strobe/acknowledge I/O bus and a dual-channel serial controller. One otherwise unused address inside the controller's register window is taken over by a local 8-bit control register. An access to that address, or to the module's identification space, is answered locally and never reaches the controller's select or strobe lines. Every other I/O-space access is forwarded to the controller with a fixed number of wait states.

The control register drives five things. The first is the controller's reset, through an active-low software bit combined with the system reset. The others are the active-low receiver enables for the two paths of each channel, and the direction enables of the shared reference clock. Some enable codes would give a receive input two drivers, or fight the clock pin. A write that carries such a code is sanitised before it is stored, and it sets a sticky error flag that the host can read. The block also stretches the controller reset to a minimum low time, and it holds off controller accesses for a recovery window after reset is released.

Top module: `sermod_ctl_glue`

## Requirements
- R1: After system reset the control register reads 0xFF in bits 7:0 and the error flag (read bit 8) is 0. Both receiver enables of each channel are inactive (1), `refclk_out_en` is 1 and `refclk_in_en_n` is 1. `ser_rst_n` is low when reset is released.
- R2: Register writes store only wdata bits 7:0, and wdata bits 15:8 are discarded. Bit 1 has no function but stores the written value and returns it on read.
- R3: `ser_rst_n` is low whenever the system reset or register bit 0 is low (bit 0 is the active-low software reset).
- R4: Once its source is released, `ser_rst_n` stays low for at least RST_LO_CYC more cycles (ceil(170 ns / clock period)). After it rises, no controller strobe is asserted for at least RST_HI_CYC cycles (ceil(70 ns / clock period)). Controller accesses made in that time are stalled, not dropped.
- R5: Bits 3:2 are the active-low enables for channel A, covering the single-ended/RS-422 path (bit 2) and the RS-485 path (bit 3). Bits 5:4 are the same pair for channel B. A written pair of 00 is stored as 11.
- R6: Bit 6 = 1 enables the reference-clock output driver, and bit 7 = 0 enables the reference-clock input. A written {bit7,bit6} of 01 is stored as 10.
- R7: Any write that has an invalid code in R5 or R6 sets the error flag. The flag stays set through later valid writes and is cleared only by system reset.
- R8: An I/O access at CTRL_ADDR asserts none of `ser_cs_n`, `ser_rd_n`, `ser_wr_n`, and `bus_ack` comes in the first cycle after the request is sampled.
- R9: Any other I/O access asserts `ser_cs_n` and the matching `ser_rd_n`/`ser_wr_n` for exactly WAIT_N cycles, with the write data forwarded. `bus_ack` follows in the next cycle as a one-cycle pulse, with read data taken from `ser_rdata`.
- R10: An ID-space access asserts no controller strobe and acknowledges in the first cycle. On a read it returns `id_rdata` in bits 7:0.
- R11: A byte access to the register uses data bits 7:0 exactly like a word access.
- R12: Pins follow the stored bits: `rxa_se_en_n`=bit 2, `rxa_485_en_n`=bit 3, `rxb_se_en_n`=bit 4, `rxb_485_en_n`=bit 5, `refclk_out_en`=bit 6, `refclk_in_en_n`=bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| bus_io_sel | input | 1 | I/O-space request, held until acknowledge |
| bus_id_sel | input | 1 | ID-space request, held until acknowledge |
| bus_we | input | 1 | 1 = write |
| bus_byte | input | 1 | 1 = byte access on bits 7:0 |
| bus_addr | input | ADDR_W | Byte offset in I/O space |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with acknowledge |
| bus_ack | output | 1 | One-cycle completion pulse |
| ser_cs_n | output | 1 | Controller chip select |
| ser_rd_n | output | 1 | Controller read strobe |
| ser_wr_n | output | 1 | Controller write strobe |
| ser_byte | output | 1 | Byte-access indication to controller |
| ser_addr | output | ADDR_W | Address to controller |
| ser_wdata | output | 16 | Write data to controller |
| ser_rdata | input | 16 | Read data from controller |
| ser_rst_n | output | 1 | Controller reset, active low |
| id_rdata | input | 8 | Identification data byte |
| rxa_se_en_n | output | 1 | Channel A single-ended/RS-422 receiver enable, low active |
| rxa_485_en_n | output | 1 | Channel A RS-485 receiver enable, low active |
| rxb_se_en_n | output | 1 | Channel B single-ended/RS-422 receiver enable, low active |
| rxb_485_en_n | output | 1 | Channel B RS-485 receiver enable, low active |
| refclk_out_en | output | 1 | Reference-clock driver enable |
| refclk_in_en_n | output | 1 | Reference-clock input enable, low active |
| cfg_err | output | 1 | Sticky invalid-configuration flag |

## Verification
The bound checker watches several properties on every cycle. It checks that no enable pair ever sits in an invalid code, that local and ID accesses never touch the controller strobes, and that a low software bit always holds the controller in reset. It also checks that the error flag never clears on its own, that strobe bursts last exactly WAIT_N cycles, and that no strobe appears inside the recovery window. Other behaviour can only be shown by the bench's scenarios. These are the concrete sanitised values stored for each bad code, the discarding of upper data bits and the bit-1 echo, and acknowledge latency counted from the request. They also cover data returned from the controller and the ID byte, the measured reset low time, and the stalled access that completes after recovery.

// File: rtl/sermod_pkg.sv
package sermod_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SER,
    ST_ACK,
    ST_REL
  } acc_state_t;

  localparam int unsigned CH_N = 2;

  // Whole clock cycles needed to cover a time in ns.
  function automatic int unsigned cyc_ceil(input int unsigned ns, input int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  // A receiver pair with both active-low enables asserted.
  function automatic logic pair_bad(input logic [1:0] p);
    return p == 2'b00;
  endfunction

  // {in_en_n, out_en}: input enabled while output driven.
  function automatic logic clk_bad(input logic [1:0] p);
    return p == 2'b01;
  endfunction

  function automatic logic cfg_bad(input logic [7:0] v);
    logic bad;
    bad = clk_bad(v[7:6]);
    for (int ch = 0; ch < CH_N; ch++)
      if (pair_bad(v[2+2*ch +: 2])) bad = 1'b1;
    return bad;
  endfunction

  function automatic logic [7:0] sanitize(input logic [7:0] v);
    logic [7:0] r;
    r = v;
    for (int ch = 0; ch < CH_N; ch++)
      if (pair_bad(v[2+2*ch +: 2])) r[2+2*ch +: 2] = 2'b11;
    if (clk_bad(v[7:6])) r[7:6] = 2'b10;
    return r;
  endfunction

endpackage

// File: rtl/sermod_ctl_reg.sv
module sermod_ctl_reg
  import sermod_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] ctrl_q,
  output logic       cfg_err,
  output logic       wr_bad
);

  assign wr_bad = wr_en & cfg_bad(wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= 8'hFF;
      cfg_err <= 1'b0;
    end else begin
      if (wr_en)  ctrl_q  <= sanitize(wdata);
      if (wr_bad) cfg_err <= 1'b1;
    end
  end

endmodule

// File: rtl/sermod_rst_seq.sv
module sermod_rst_seq #(
  parameter int unsigned LO_CYC = 22,
  parameter int unsigned HI_CYC = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_n,
  output logic ser_rst_n,
  output logic ser_ready
);

  localparam int unsigned LO_W = $clog2(LO_CYC + 1);
  localparam int unsigned HI_W = $clog2(HI_CYC + 1);

  logic [LO_W-1:0] lo_cnt;
  logic [HI_W-1:0] hi_cnt;

  assign ser_rst_n = rst_n & soft_n & (lo_cnt == '0);
  assign ser_ready = ser_rst_n & (hi_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= LO_W'(LO_CYC);
      hi_cnt <= HI_W'(HI_CYC);
    end else begin
      if (!soft_n)           lo_cnt <= LO_W'(LO_CYC);
      else if (lo_cnt != '0) lo_cnt <= lo_cnt - 1'b1;
      if (!ser_rst_n)        hi_cnt <= HI_W'(HI_CYC);
      else if (hi_cnt != '0) hi_cnt <= hi_cnt - 1'b1;
    end
  end

endmodule

// File: rtl/sermod_acc_fsm.sv
module sermod_acc_fsm
  import sermod_pkg::*;
#(
  parameter int unsigned ADDR_W    = 7,
  parameter int unsigned CTRL_ADDR = 'h0A,
  parameter int unsigned WAIT_N    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_sel,
  input  logic              id_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ser_ready,
  output logic              local_go,
  output logic              ser_last,
  output logic              strobe,
  output logic              ack
);

  localparam int unsigned WCNT_W = $clog2(WAIT_N + 1);

  acc_state_t        st;
  logic [WCNT_W-1:0] wcnt;
  logic              local_hit, ser_go, idle;

  assign idle      = (st == ST_IDLE);
  assign local_hit = io_sel && (addr == ADDR_W'(CTRL_ADDR));
  assign local_go  = idle && (id_sel || local_hit);
  assign ser_go    = idle && io_sel && !local_hit && !id_sel && ser_ready;
  assign strobe    = (st == ST_SER);
  assign ser_last  = strobe && (wcnt == WCNT_W'(WAIT_N - 1));
  assign ack       = (st == ST_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      wcnt <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          wcnt <= '0;
          if (local_go)    st <= ST_ACK;
          else if (ser_go) st <= ST_SER;
        end
        ST_SER: begin
          if (ser_last) st <= ST_ACK;
          else          wcnt <= wcnt + 1'b1;
        end
        ST_ACK:  st <= (io_sel || id_sel) ? ST_REL : ST_IDLE;
        default: if (!(io_sel || id_sel)) st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sermod_ctl_glue.sv
module sermod_ctl_glue
  import sermod_pkg::*;
#(
  parameter int unsigned ADDR_W    = 7,
  parameter int unsigned CTRL_ADDR = 'h0A,
  parameter int unsigned WAIT_N    = 3,
  parameter int unsigned CLK_NS    = 8,
  parameter int unsigned RST_LO_NS = 170,
  parameter int unsigned RST_HI_NS = 70
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_io_sel,
  input  logic              bus_id_sel,
  input  logic              bus_we,
  input  logic              bus_byte,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              bus_ack,
  output logic              ser_cs_n,
  output logic              ser_rd_n,
  output logic              ser_wr_n,
  output logic              ser_byte,
  output logic [ADDR_W-1:0] ser_addr,
  output logic [15:0]       ser_wdata,
  input  logic [15:0]       ser_rdata,
  output logic              ser_rst_n,
  input  logic [7:0]        id_rdata,
  output logic              rxa_se_en_n,
  output logic              rxa_485_en_n,
  output logic              rxb_se_en_n,
  output logic              rxb_485_en_n,
  output logic              refclk_out_en,
  output logic              refclk_in_en_n,
  output logic              cfg_err
);

  localparam int unsigned RST_LO_CYC = cyc_ceil(RST_LO_NS, CLK_NS);
  localparam int unsigned RST_HI_CYC = cyc_ceil(RST_HI_NS, CLK_NS);

  // Named internal events, also used by the bound checker.
  logic       local_go, ser_last, strobe;
  logic       reg_wr, cfg_write_bad, soft_rst_n, ser_ready;
  logic [7:0] ctrl_q;

  sermod_acc_fsm #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .WAIT_N(WAIT_N)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .io_sel(bus_io_sel), .id_sel(bus_id_sel),
    .addr(bus_addr), .ser_ready(ser_ready), .local_go(local_go),
    .ser_last(ser_last), .strobe(strobe), .ack(bus_ack)
  );

  assign reg_wr = local_go && !bus_id_sel && bus_we;

  sermod_ctl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wdata(bus_wdata[7:0]),
    .ctrl_q(ctrl_q), .cfg_err(cfg_err), .wr_bad(cfg_write_bad)
  );

  assign soft_rst_n = ctrl_q[0];

  sermod_rst_seq #(.LO_CYC(RST_LO_CYC), .HI_CYC(RST_HI_CYC)) u_rst (
    .clk(clk), .rst_n(rst_n), .soft_n(soft_rst_n),
    .ser_rst_n(ser_rst_n), .ser_ready(ser_ready)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (local_go)
      bus_rdata <= bus_id_sel ? {8'h00, id_rdata} : {7'h00, cfg_err, ctrl_q};
    else if (ser_last)
      bus_rdata <= ser_rdata;
  end

  assign ser_cs_n  = !strobe;
  assign ser_rd_n  = !(strobe && !bus_we);
  assign ser_wr_n  = !(strobe && bus_we);
  assign ser_byte  = bus_byte;
  assign ser_addr  = bus_addr;
  assign ser_wdata = bus_wdata;

  assign rxa_se_en_n    = ctrl_q[2];
  assign rxa_485_en_n   = ctrl_q[3];
  assign rxb_se_en_n    = ctrl_q[4];
  assign rxb_485_en_n   = ctrl_q[5];
  assign refclk_out_en  = ctrl_q[6];
  assign refclk_in_en_n = ctrl_q[7];

endmodule

// File: rtl/sermod_ctl_glue_chk.sv
module sermod_ctl_glue_chk #(
  parameter int unsigned ADDR_W     = 7,
  parameter int unsigned CTRL_ADDR  = 'h0A,
  parameter int unsigned WAIT_N     = 3,
  parameter int unsigned RST_HI_CYC = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_io_sel,
  input logic              bus_id_sel,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_ack,
  input logic              ser_cs_n,
  input logic              ser_rst_n,
  input logic              soft_rst_n,
  input logic              cfg_err,
  input logic              cfg_write_bad,
  input logic              rxa_se_en_n,
  input logic              rxa_485_en_n,
  input logic              rxb_se_en_n,
  input logic              rxb_485_en_n,
  input logic              refclk_out_en,
  input logic              refclk_in_en_n
);

  localparam int unsigned RISE_W = $clog2(RST_HI_CYC + 2);
  localparam int unsigned RUN_W  = $clog2(WAIT_N + 2);

  logic [RISE_W-1:0] since_rise;
  logic [RUN_W-1:0]  strobe_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rise <= '0;
      strobe_run <= '0;
    end else begin
      if (!ser_rst_n) since_rise <= '0;
      else if (since_rise <= RISE_W'(RST_HI_CYC)) since_rise <= since_rise + 1'b1;
      if (ser_cs_n) strobe_run <= '0;
      else          strobe_run <= strobe_run + 1'b1;
    end
  end

  p_local_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_io_sel && bus_addr == ADDR_W'(CTRL_ADDR)) |-> ser_cs_n);
  p_id_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_id_sel |-> ser_cs_n);
  p_pair_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rxa_se_en_n && !rxa_485_en_n));
  p_pair_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rxb_se_en_n && !rxb_485_en_n));
  p_clk_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(refclk_out_en && !refclk_in_en_n));
  p_soft_rst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst_n |-> !ser_rst_n);
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
  p_bad_sets_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_write_bad |=> cfg_err);
  p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack);
  p_strobe_max_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_cs_n |-> strobe_run < RUN_W'(WAIT_N));
  p_strobe_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_cs_n) |-> strobe_run == RUN_W'(WAIT_N));
  p_recover_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_cs_n |-> since_rise > RISE_W'(RST_HI_CYC));

endmodule

bind sermod_ctl_glue sermod_ctl_glue_chk #(
  .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .WAIT_N(WAIT_N), .RST_HI_CYC(RST_HI_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_io_sel(bus_io_sel), .bus_id_sel(bus_id_sel),
  .bus_addr(bus_addr), .bus_ack(bus_ack), .ser_cs_n(ser_cs_n),
  .ser_rst_n(ser_rst_n), .soft_rst_n(soft_rst_n), .cfg_err(cfg_err),
  .cfg_write_bad(cfg_write_bad), .rxa_se_en_n(rxa_se_en_n),
  .rxa_485_en_n(rxa_485_en_n), .rxb_se_en_n(rxb_se_en_n),
  .rxb_485_en_n(rxb_485_en_n), .refclk_out_en(refclk_out_en),
  .refclk_in_en_n(refclk_in_en_n)
);

// File: tb/sermod_ctl_glue_tb.sv
module sermod_ctl_glue_tb;

  localparam int WAIT_N = 3;
  localparam int LO_MIN = 22;  // 170 ns at 8 ns, rounded up
  localparam int HI_MIN = 9;   // 70 ns at 8 ns, rounded up
  localparam logic [6:0] REG_A = 7'h0A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_io_sel = 1'b0, bus_id_sel = 1'b0, bus_we = 1'b0, bus_byte = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata, ser_wdata, ser_rdata;
  logic        bus_ack, ser_cs_n, ser_rd_n, ser_wr_n, ser_byte, ser_rst_n;
  logic [6:0]  ser_addr;
  logic [7:0]  id_rdata = 8'h49;
  logic        rxa_se_en_n, rxa_485_en_n, rxb_se_en_n, rxb_485_en_n;
  logic        refclk_out_en, refclk_in_en_n, cfg_err;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  assign ser_rdata = 16'hC000 | {9'h000, ser_addr};

  sermod_ctl_glue u_dut (
    .clk(clk), .rst_n(rst_n), .bus_io_sel(bus_io_sel), .bus_id_sel(bus_id_sel),
    .bus_we(bus_we), .bus_byte(bus_byte), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .ser_cs_n(ser_cs_n), .ser_rd_n(ser_rd_n),
    .ser_wr_n(ser_wr_n), .ser_byte(ser_byte), .ser_addr(ser_addr), .ser_wdata(ser_wdata),
    .ser_rdata(ser_rdata), .ser_rst_n(ser_rst_n), .id_rdata(id_rdata),
    .rxa_se_en_n(rxa_se_en_n), .rxa_485_en_n(rxa_485_en_n), .rxb_se_en_n(rxb_se_en_n),
    .rxb_485_en_n(rxb_485_en_n), .refclk_out_en(refclk_out_en),
    .refclk_in_en_n(refclk_in_en_n), .cfg_err(cfg_err)
  );

  // Reset-timing monitor, sampled away from the active edge.
  int  low_run = 0, last_low_run = 0, since_rise = 0, gap = 0;
  bit  armed = 1'b0;
  always @(negedge clk) begin
    if (!ser_rst_n) begin
      low_run++; since_rise = 0; armed = 1'b1;
    end else begin
      if (low_run != 0) last_low_run = low_run;
      low_run = 0;
      since_rise++;
      if (!ser_cs_n && armed) begin gap = since_rise; armed = 1'b0; end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit io, input bit id, input bit we, input bit byt,
                     input logic [6:0] a, input logic [15:0] wd,
                     output logic [15:0] rd, output int cyc, output int strb,
                     output bit rd_seen, output bit wr_seen, output bit wd_ok);
    @(negedge clk);
    bus_io_sel = io; bus_id_sel = id; bus_we = we; bus_byte = byt;
    bus_addr = a; bus_wdata = wd;
    cyc = 0; strb = 0; rd_seen = 0; wr_seen = 0; wd_ok = 1;
    do begin
      @(negedge clk);
      cyc++;
      if (!ser_cs_n) begin
        strb++;
        if (!ser_rd_n) rd_seen = 1;
        if (!ser_wr_n) wr_seen = 1;
        if (ser_wdata !== wd) wd_ok = 0;
      end
    end while (!bus_ack && cyc < 200);
    rd = bus_rdata;
    bus_io_sel = 0; bus_id_sel = 0; bus_we = 0; bus_byte = 0;
  endtask

  task automatic wr_reg(input logic [15:0] v, input bit byt);
    logic [15:0] rd; int c, s; bit r, w, k;
    acc(1, 0, 1, byt, REG_A, v, rd, c, s, r, w, k);
  endtask

  task automatic rd_reg(output logic [15:0] rd);
    int c, s; bit r, w, k;
    acc(1, 0, 0, 0, REG_A, 16'h0, rd, c, s, r, w, k);
  endtask

  task automatic t_reset();
    logic [15:0] rd;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ser_rst_n low after release", ser_rst_n, 0);
    chk("R1 rx enables idle", {rxb_485_en_n, rxb_se_en_n, rxa_485_en_n, rxa_se_en_n}, 4'hF);
    chk("R1 refclk pins", {refclk_in_en_n, refclk_out_en}, 2'b11);
    repeat (40) @(negedge clk);
    rd_reg(rd);
    chk("R1 reset value", rd[8:0], 9'h0FF);
  endtask

  task automatic t_storage();
    logic [15:0] rd;
    wr_reg(16'hA5E7, 0);
    rd_reg(rd);
    chk("R2 upper discarded, bit1=1", rd[7:0], 8'hE7);
    chk("R7 no error on valid write", rd[8], 0);
    wr_reg(16'h00E5, 0);
    rd_reg(rd);
    chk("R2 bit1 cleared", rd[7:0], 8'hE5);
  endtask

  task automatic t_outputs();
    wr_reg(16'h00E7, 0);
    @(negedge clk);
    chk("R12 pins for E7",
        {refclk_in_en_n, refclk_out_en, rxb_485_en_n, rxb_se_en_n, rxa_485_en_n, rxa_se_en_n},
        6'b111001);
  endtask

  task automatic t_byte();
    logic [15:0] rd;
    wr_reg(16'h33DB, 1);
    rd_reg(rd);
    chk("R11 byte write", rd[7:0], 8'hDB);
  endtask

  task automatic t_local_timing();
    logic [15:0] rd; int c, s; bit r, w, k;
    acc(1, 0, 0, 0, REG_A, 16'h0, rd, c, s, r, w, k);
    chk("R8 local ack latency", c, 1);
    chk("R8 local no strobe", s, 0);
    acc(0, 1, 0, 0, 7'h05, 16'h0, rd, c, s, r, w, k);
    chk("R10 id data", rd[7:0], 8'h49);
    chk("R10 id latency", c, 1);
    chk("R10 id no strobe", s, 0);
  endtask

  task automatic t_serial();
    logic [15:0] rd; int c, s; bit r, w, k;
    acc(1, 0, 0, 0, 7'h20, 16'h0, rd, c, s, r, w, k);
    chk("R9 read strobe cycles", s, WAIT_N);
    chk("R9 read ack cycle", c, WAIT_N + 1);
    chk("R9 read data", rd, 16'hC020);
    chk("R9 read strobe kind", {r, w}, 2'b10);
    acc(1, 0, 1, 0, 7'h40, 16'h1234, rd, c, s, r, w, k);
    chk("R9 write strobe cycles", s, WAIT_N);
    chk("R9 write strobe kind", {r, w}, 2'b01);
    chk("R9 write data forwarded", k, 1);
  endtask

  task automatic t_clock();
    logic [15:0] rd;
    wr_reg(16'h0017, 0);
    rd_reg(rd);
    chk("R6 input mode stored", rd[7:0], 8'h17);
    chk("R12 input mode pins", {refclk_in_en_n, refclk_out_en}, 2'b00);
    chk("R7 valid clock code no error", rd[8], 0);
    wr_reg(16'h0057, 0);
    rd_reg(rd);
    chk("R6 bad clock code sanitised", rd[7:0], 8'h97);
    chk("R6 pins after bad clock code", {refclk_in_en_n, refclk_out_en}, 2'b10);
    chk("R7 error set", rd[8], 1);
  endtask

  task automatic t_bad_pairs();
    logic [15:0] rd;
    wr_reg(16'h00DB, 0);
    wr_reg(16'h00D3, 0);
    rd_reg(rd);
    chk("R5 channel A 00 stored as 11", rd[7:0], 8'hDF);
    wr_reg(16'h00D7, 0);
    wr_reg(16'h00C7, 0);
    rd_reg(rd);
    chk("R5 channel B 00 stored as 11", rd[7:0], 8'hF7);
    chk("R5 channel B pins", {rxb_485_en_n, rxb_se_en_n}, 2'b11);
  endtask

  task automatic t_sticky();
    logic [15:0] rd;
    wr_reg(16'h00E7, 0);
    rd_reg(rd);
    chk("R7 error stays after valid write", rd[8], 1);
    chk("R7 cfg_err pin", cfg_err, 1);
  endtask

  task automatic t_soft_reset();
    logic [15:0] rd; int c, s; bit r, w, k;
    wr_reg(16'h00FE, 0);
    chk("R3 soft reset drives ser_rst_n", ser_rst_n, 0);
    wr_reg(16'h00FF, 0);
    acc(1, 0, 0, 0, 7'h22, 16'h0, rd, c, s, r, w, k);
    chk("R4 stalled access completes", rd, 16'hC022);
    chk("R4 stalled access strobes", s, WAIT_N);
    checks++;
    if (last_low_run < LO_MIN + 1) begin
      errors++;
      $display("FAIL R4 low time actual=%0d expected>=%0d", last_low_run, LO_MIN + 1);
    end
    checks++;
    if (gap <= HI_MIN) begin
      errors++;
      $display("FAIL R4 recovery gap actual=%0d expected>%0d", gap, HI_MIN);
    end
  endtask

  task automatic t_sys_reset_clear();
    logic [15:0] rd;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R3 system reset drives ser_rst_n", ser_rst_n, 0);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    rd_reg(rd);
    chk("R7 error cleared by system reset", rd[8:0], 9'h0FF);
  endtask

  initial begin
    t_reset();
    t_storage();
    t_outputs();
    t_byte();
    t_local_timing();
    t_serial();
    t_clock();
    t_bad_pairs();
    t_sticky();
    t_soft_reset();
    t_sys_reset_clear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule